// File: doc/BRIEF.md
# Half-Duplex UART with Line Collision Detection

This block sends and receives asynchronous serial characters on a single shared wire, such as an open-drain bus where every node both drives and listens. Each character has a start bit, a nine-bit payload and one stop bit, with no parity. A higher protocol layer can use one such character to carry a single symbol of its own bus. While its own character is on the wire, the block compares the level it drives with the level it reads back. If another node pulls the wire against it, the block raises a collision interrupt. It can also withdraw its own transmit permission, so that no further characters leave until software grants it again.

The bit clock comes from an 8-bit reload divider. The divider counts either system clock cycles or rising edges of an external clock, and it produces ticks at OVS times the bit rate. Configuration inputs select the following:
- the point in each bit at which the collision comparison is made;
- whether a queued character leaves at once or waits for a falling edge on the wire;
- whether both pins are inverted;
- whether a collision clears transmit permission.

Status outputs report the state of the transmit buffer and shift register, receive completion, and overrun, framing and parity errors together with their OR.

Top module: `uart_buscol`

## Requirements
- R1: After reset, txd is at its idle level (1 when cfg_inv=0), tx_buf_empty=1, tx_reg_empty=1, tx_en=0, rx_done=0, and all error flags are 0.
- R2: A frame is sent LSB first: one 0 start bit, then tx_data[0] to tx_data[8], then one 1 stop bit. With the internal source, each bit lasts OVS*(cfg_div+1) clock cycles, so a frame is 11*OVS*(cfg_div+1) cycles.
- R3: A tx_wr pulse fills the transmit buffer, so tx_buf_empty is 0 in the next cycle. When tx_en=1 and the shift register is free, the buffer moves to the shift register and tx_buf_empty returns to 1. tx_reg_empty is 0 from that move until the stop bit ends.
- R4: With cfg_start_rx=0, a loaded character starts at once. With cfg_start_rx=1, txd stays idle until a falling edge is seen on the polarity-corrected rxd, and the character then starts.
- R5: With rx_en=1, a falling edge on rxd starts reception, and each bit is sampled at tick OVS/2 of its period. rx_data takes the nine payload bits and rx_done is set. An rx_rd pulse clears rx_done.
- R6: If a frame completes while rx_done is still 1, err_ovr is set and rx_data holds the newer frame. rx_rd clears it.
- R7: If the stop bit is sampled as 0, err_frm is set with rx_done. rx_rd clears it.
- R8: err_par is always 0, because parity is disabled. err_sum is the OR of err_ovr, err_frm and err_par.
- R9: During a frame, a mismatch between the driven bit and the sampled rxd at the comparison point gives irq_col a one-cycle pulse.
- R10: With cfg_col_end=0, the comparison is made at the middle of each bit (tick OVS/2). With cfg_col_end=1, it is made at the last tick of each bit.
- R11: No comparison is made while the transmitter is idle or waiting for its start condition. A wire pulled low at those times gives no irq_col.
- R12: With cfg_auto_clr=1, a collision clears tx_en. The current frame still finishes, and a character written afterwards stays queued until te_set. With cfg_auto_clr=0, tx_en is not changed by a collision.
- R13: With cfg_inv=1, txd is the inverse of the internal line (idle 0, start bit 1), and rxd is inverted before use. Loopback data is unchanged.
- R14: With cfg_ext_src=1, the divider counts synchronized rising edges of ext_clk instead of clock cycles. With ext_clk still, a frame makes no progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_div | input | 8 | Divider reload; tick every cfg_div+1 source events |
| cfg_ext_src | input | 1 | 1: count ext_clk rising edges |
| ext_clk | input | 1 | External count source |
| cfg_inv | input | 1 | Invert txd and rxd |
| cfg_start_rx | input | 1 | 1: start transmission on rxd falling edge |
| cfg_col_end | input | 1 | 0: compare mid-bit, 1: compare at bit end |
| cfg_auto_clr | input | 1 | Clear tx_en on collision |
| te_set | input | 1 | Pulse: grant transmit permission |
| te_clr | input | 1 | Pulse: withdraw transmit permission |
| rx_en | input | 1 | Receiver enable |
| tx_wr | input | 1 | Pulse: write tx_data into the buffer |
| tx_data | input | 9 | Character to send |
| rx_rd | input | 1 | Pulse: acknowledge received data and errors |
| rx_data | output | 9 | Last received character |
| txd | output | 1 | Serial output pin |
| rxd | input | 1 | Serial input pin |
| tx_en | output | 1 | Transmit permission state |
| irq_col | output | 1 | Collision interrupt pulse |
| tx_buf_empty | output | 1 | Transmit buffer free |
| tx_reg_empty | output | 1 | Shift register idle |
| rx_done | output | 1 | Received character available |
| err_ovr | output | 1 | Overrun error |
| err_frm | output | 1 | Framing error |
| err_par | output | 1 | Parity error (never set) |
| err_sum | output | 1 | OR of error flags |

## Verification
tx_buf_empty falls one clock after tx_wr. txd leaves idle one clock later, on the cycle that moves the buffer to the shift register. The bench polls for that edge, then samples every bit eight cycles into its 16-cycle period and measures the full frame against the 176-cycle figure, with one cycle of tick-phase slack. The collision comparison sees rxd two clocks late because of the synchronizer. Jamming windows are therefore placed at offsets from the observed start edge that the middle-of-bit point cannot reach and the end-of-bit point cannot miss. Receive and error flags are read only after tx_reg_empty returns, which falls after the receiver's stop-bit sample.

// File: rtl/ubc_pkg.sv
package ubc_pkg;
   typedef enum logic [1:0] {TX_IDLE, TX_WAIT, TX_SEND} tx_state_e;
   typedef enum logic {RX_IDLE, RX_RECV} rx_state_e;
endpackage

// File: rtl/ubc_sync.sv
module ubc_sync #(
   parameter int   N  = 2,
   parameter logic RV = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [N-1:0] r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= {N{RV}};
      else        r <= {r[N-2:0], d};
   end

   assign q = r[N-1];
endmodule

// File: rtl/ubc_baud.sv
module ubc_baud #(
   parameter int DIV_W   = 8,
   parameter int SYNC_N  = 2,
   parameter bit HAS_EXT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   input  logic             ext_sel,
   input  logic             ext_clk,
   output logic             tick
);
   logic             src_evt;
   logic [DIV_W-1:0] cnt;

   generate
      if (HAS_EXT) begin : g_ext
         logic ext_s, ext_q;
         ubc_sync #(.N(SYNC_N), .RV(1'b0)) u_ext_sync (
            .clk(clk), .rst_n(rst_n), .d(ext_clk), .q(ext_s));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ext_q <= 1'b0;
            else        ext_q <= ext_s;
         end
         assign src_evt = ext_sel ? (ext_s & ~ext_q) : 1'b1;
      end else begin : g_int
         assign src_evt = 1'b1;
      end
   endgenerate

   assign tick = src_evt && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (src_evt) cnt <= (cnt == '0) ? div : cnt - 1'b1;
   end

   // two ticks are never adjacent unless the divider is zero
   AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(tick) && div != '0 && $past(div) == div) |-> !tick); // R2
endmodule

// File: rtl/ubc_tx.sv
module ubc_tx import ubc_pkg::*; #(
   parameter int DW  = 9,
   parameter int OVS = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          tx_en,
   input  logic          start_rx,
   input  logic          col_end,
   input  logic          rx_line,
   input  logic          rx_fall,
   input  logic          buf_valid,
   input  logic [DW-1:0] buf_data,
   output logic          take,
   output logic          line,
   output logic          busy,
   output logic          col_evt
);
   localparam int FB   = DW + 2;
   localparam int PH_W = $clog2(OVS);
   localparam int BC_W = $clog2(FB);
   localparam logic [PH_W-1:0] PH_MID  = PH_W'(OVS/2 - 1);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);
   localparam logic [BC_W-1:0] BC_LAST = BC_W'(FB - 1);

   tx_state_e       st;
   logic [FB-1:0]   sh;
   logic [PH_W-1:0] ph;
   logic [BC_W-1:0] bc;
   logic            at_pt;

   assign take    = (st == TX_IDLE) && buf_valid && tx_en;
   assign line    = (st == TX_SEND) ? sh[0] : 1'b1;
   assign busy    = (st != TX_IDLE);
   assign at_pt   = col_end ? (ph == PH_LAST) : (ph == PH_MID);
   assign col_evt = (st == TX_SEND) && tick && at_pt && (sh[0] != rx_line);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= TX_IDLE;
         sh <= '1;
         ph <= '0;
         bc <= '0;
      end else begin
         case (st)
            TX_IDLE: if (take) begin
               sh <= {1'b1, buf_data, 1'b0};
               ph <= '0;
               bc <= '0;
               st <= start_rx ? TX_WAIT : TX_SEND;
            end
            TX_WAIT: if (rx_fall) begin
               ph <= '0;
               st <= TX_SEND;
            end
            TX_SEND: if (tick) begin
               if (ph == PH_LAST) begin
                  ph <= '0;
                  sh <= {1'b1, sh[FB-1:1]};
                  if (bc == BC_LAST) st <= TX_IDLE;
                  else               bc <= bc + 1'b1;
               end else begin
                  ph <= ph + 1'b1;
               end
            end
            default: st <= TX_IDLE;
         endcase
      end
   end

   AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TX_WAIT && !rx_fall) |=> (st == TX_WAIT)); // R4
   AST_BIT_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TX_SEND) |-> (bc <= BC_LAST)); // R2
endmodule

// File: rtl/ubc_rx.sv
module ubc_rx import ubc_pkg::*; #(
   parameter int DW  = 9,
   parameter int OVS = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          rx_en,
   input  logic          rx_line,
   input  logic          rx_fall,
   input  logic          rd,
   output logic [DW-1:0] data,
   output logic          done,
   output logic          ovr,
   output logic          frm
);
   localparam int FB   = DW + 2;
   localparam int PH_W = $clog2(OVS);
   localparam int BC_W = $clog2(FB);
   localparam logic [PH_W-1:0] PH_MID  = PH_W'(OVS/2 - 1);
   localparam logic [BC_W-1:0] BC_LAST = BC_W'(FB - 1);

   rx_state_e       st;
   logic [PH_W-1:0] ph;
   logic [BC_W-1:0] bc;
   logic [DW-1:0]   sh;
   logic            samp, comp;

   assign samp = (st == RX_RECV) && tick && (ph == PH_MID);
   assign comp = samp && (bc == BC_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= RX_IDLE;
         ph   <= '0;
         bc   <= '0;
         sh   <= '0;
         data <= '0;
         done <= 1'b0;
         ovr  <= 1'b0;
         frm  <= 1'b0;
      end else begin
         case (st)
            RX_IDLE: if (rx_en && rx_fall) begin
               st <= RX_RECV;
               ph <= '0;
               bc <= '0;
            end
            RX_RECV: begin
               if (tick) ph <= ph + 1'b1;
               if (samp) begin
                  if (bc == '0) begin
                     if (rx_line) st <= RX_IDLE;
                     else         bc <= bc + 1'b1;
                  end else if (bc == BC_LAST) begin
                     st <= RX_IDLE;
                  end else begin
                     sh <= {rx_line, sh[DW-1:1]};
                     bc <= bc + 1'b1;
                  end
               end
            end
            default: st <= RX_IDLE;
         endcase
         if (comp) begin
            data <= sh;
            done <= 1'b1;
            ovr  <= (ovr | done) & ~rd;
            frm  <= ~rx_line;
         end else if (rd) begin
            done <= 1'b0;
            ovr  <= 1'b0;
            frm  <= 1'b0;
         end
      end
   end

   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !rd) |=> done); // R5
endmodule

// File: rtl/uart_buscol.sv
module uart_buscol #(
   parameter int DATA_W      = 9,
   parameter int DIV_W       = 8,
   parameter int OVS         = 8,
   parameter int SYNC_N      = 2,
   parameter bit HAS_EXT_SRC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              cfg_ext_src,
   input  logic              ext_clk,
   input  logic              cfg_inv,
   input  logic              cfg_start_rx,
   input  logic              cfg_col_end,
   input  logic              cfg_auto_clr,
   input  logic              te_set,
   input  logic              te_clr,
   input  logic              rx_en,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              rx_rd,
   output logic [DATA_W-1:0] rx_data,
   output logic              txd,
   input  logic              rxd,
   output logic              tx_en,
   output logic              irq_col,
   output logic              tx_buf_empty,
   output logic              tx_reg_empty,
   output logic              rx_done,
   output logic              err_ovr,
   output logic              err_frm,
   output logic              err_par,
   output logic              err_sum
);
   generate
      if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("OVS must be a power of two and at least 4");
      end
      if (SYNC_N < 2) begin : g_bad_sync
         $error("SYNC_N must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("DATA_W must be positive");
      end
   endgenerate

   logic              tick, rx_s, rx_line, rx_prev, rx_fall;
   logic              tb_full, take, tx_line, tx_busy, col_evt;
   logic [DATA_W-1:0] tb_data;

   ubc_baud #(.DIV_W(DIV_W), .SYNC_N(SYNC_N), .HAS_EXT(HAS_EXT_SRC)) u_baud (
      .clk(clk), .rst_n(rst_n), .div(cfg_div), .ext_sel(cfg_ext_src),
      .ext_clk(ext_clk), .tick(tick));

   ubc_sync #(.N(SYNC_N), .RV(1'b1)) u_rx_sync (
      .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_s));

   assign rx_line = rx_s ^ cfg_inv;
   assign rx_fall = rx_prev & ~rx_line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_prev <= 1'b0;
      else        rx_prev <= rx_line;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tb_full <= 1'b0;
         tb_data <= '0;
      end else if (tx_wr) begin
         tb_full <= 1'b1;
         tb_data <= tx_data;
      end else if (take) begin
         tb_full <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_en   <= 1'b0;
         irq_col <= 1'b0;
      end else begin
         irq_col <= col_evt;
         if (col_evt && cfg_auto_clr) tx_en <= 1'b0;
         else if (te_clr)             tx_en <= 1'b0;
         else if (te_set)             tx_en <= 1'b1;
      end
   end

   ubc_tx #(.DW(DATA_W), .OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en),
      .start_rx(cfg_start_rx), .col_end(cfg_col_end), .rx_line(rx_line),
      .rx_fall(rx_fall), .buf_valid(tb_full), .buf_data(tb_data),
      .take(take), .line(tx_line), .busy(tx_busy), .col_evt(col_evt));

   ubc_rx #(.DW(DATA_W), .OVS(OVS)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rx_en(rx_en),
      .rx_line(rx_line), .rx_fall(rx_fall), .rd(rx_rd),
      .data(rx_data), .done(rx_done), .ovr(err_ovr), .frm(err_frm));

   assign txd          = tx_line ^ cfg_inv;
   assign tx_buf_empty = ~tb_full;
   assign tx_reg_empty = ~tx_busy;
   assign err_par      = 1'b0;
   assign err_sum      = err_ovr | err_frm | err_par;

   AST_AUTO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_col && $past(cfg_auto_clr)) |-> !tx_en); // R12
   AST_WR_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      tx_wr |=> !tx_buf_empty); // R3
   AST_COL_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      irq_col |-> $past(!tx_reg_empty)); // R11
endmodule

// File: tb/test_uart_buscol.sv
module test_uart_buscol;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] cfg_div = 8'd1;
   logic       cfg_ext_src = 1'b0, ext_clk = 1'b0, cfg_inv = 1'b0;
   logic       cfg_start_rx = 1'b0, cfg_col_end = 1'b0, cfg_auto_clr = 1'b0;
   logic       te_set = 1'b0, te_clr = 1'b0, rx_en = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0;
   logic [8:0] tx_data = '0;
   logic [8:0] rx_data;
   logic       txd, rxd, tx_en, irq_col, tx_buf_empty, tx_reg_empty;
   logic       rx_done, err_ovr, err_frm, err_par, err_sum;
   logic       jam = 1'b0;
   int         vecs = 0, miss = 0, col_cnt = 0;

   always #4 clk = ~clk;

   // shared wire: a jamming node pulls the physical line to its dominant level
   assign rxd = cfg_inv ? (txd | jam) : (txd & ~jam);

   always @(posedge clk) if (irq_col) col_cnt <= col_cnt + 1;

   uart_buscol i_uart_buscol (
      .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_ext_src(cfg_ext_src),
      .ext_clk(ext_clk), .cfg_inv(cfg_inv), .cfg_start_rx(cfg_start_rx),
      .cfg_col_end(cfg_col_end), .cfg_auto_clr(cfg_auto_clr), .te_set(te_set),
      .te_clr(te_clr), .rx_en(rx_en), .tx_wr(tx_wr), .tx_data(tx_data),
      .rx_rd(rx_rd), .rx_data(rx_data), .txd(txd), .rxd(rxd), .tx_en(tx_en),
      .irq_col(irq_col), .tx_buf_empty(tx_buf_empty), .tx_reg_empty(tx_reg_empty),
      .rx_done(rx_done), .err_ovr(err_ovr), .err_frm(err_frm),
      .err_par(err_par), .err_sum(err_sum));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         miss++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push(input logic [8:0] d);
      tx_data = d;
      tx_wr   = 1'b1;
      @(negedge clk);
      tx_wr   = 1'b0;
   endtask

   task automatic pulse_rd();
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
   endtask

   task automatic pulse_te();
      te_set = 1'b1;
      @(negedge clk);
      te_set = 1'b0;
   endtask

   task automatic find_start(input int maxc, output int w);
      w = 0;
      while (txd !== cfg_inv && w < maxc) begin
         @(negedge clk);
         w++;
      end
   endtask

   task automatic wait_idle(input int maxc, output int n);
      n = 0;
      while (!(tx_reg_empty && tx_buf_empty) && n < maxc) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
   endtask

   task automatic t_reset();
      chk("R1 txd idle", txd, 1);
      chk("R1 tx_buf_empty", tx_buf_empty, 1);
      chk("R1 tx_reg_empty", tx_reg_empty, 1);
      chk("R1 tx_en", tx_en, 0);
      chk("R1 rx_done", rx_done, 0);
      chk("R1 err_sum", {err_ovr, err_frm, err_par, err_sum}, 0);
   endtask

   task automatic t_frame();
      logic [10:0] fr;
      int w, n;
      fr = {1'b1, 9'h1A5, 1'b0};
      rx_en = 1'b1;
      pulse_te();
      chk("R3 tx_en granted", tx_en, 1);
      push(9'h1A5);
      chk("R3 buffer filled", tx_buf_empty, 0);
      find_start(20, w);
      chk("R3 start seen", w < 20, 1);
      chk("R3 shift busy", tx_reg_empty, 0);
      chk("R3 buffer moved", tx_buf_empty, 1);
      wait_n(8);
      for (int k = 0; k < 11; k++) begin
         chk($sformatf("R2 bit %0d", k), txd, fr[k]);
         if (k < 10) wait_n(16);
      end
      wait_idle(40, n);
      chk("R2 frame length", (168 + n >= 174) && (168 + n <= 177), 1);
      chk("R5 rx_done", rx_done, 1);
      chk("R5 rx_data", rx_data, 9'h1A5);
      chk("R5 no error", err_sum, 0);
      pulse_rd();
      chk("R5 rx_rd clears", rx_done, 0);
   endtask

   task automatic t_inv();
      int w, n;
      cfg_inv = 1'b1;
      wait_n(5);
      chk("R13 idle inverted", txd, 0);
      push(9'h0F3);
      find_start(20, w);
      chk("R13 start bit inverted", txd, 1);
      wait_idle(300, n);
      chk("R13 loopback data", rx_data, 9'h0F3);
      chk("R13 loopback done", rx_done, 1);
      pulse_rd();
      cfg_inv = 1'b0;
      wait_n(40);
   endtask

   task automatic t_start_wait();
      int w, n, c;
      cfg_start_rx = 1'b1;
      push(9'h155);
      wait_n(120);
      chk("R4 held idle", txd, 1);
      chk("R4 register loaded", tx_reg_empty, 0);
      chk("R4 buffer moved", tx_buf_empty, 1);
      c = col_cnt;
      jam = 1'b1;
      wait_n(3);
      jam = 1'b0;
      find_start(10, w);
      chk("R4 starts on edge", w < 10, 1);
      wait_idle(300, n);
      chk("R11 no compare while waiting", col_cnt, c);
      chk("R4 data received", rx_data, 9'h155);
      pulse_rd();
      cfg_start_rx = 1'b0;
   endtask

   task automatic t_idle_jam();
      int c;
      c = col_cnt;
      jam = 1'b1;
      wait_n(40);
      jam = 1'b0;
      wait_n(250);
      chk("R11 idle jam ignored", col_cnt, c);
      pulse_rd();
   endtask

   task automatic t_col_point(input logic at_end, input int exp_cnt);
      int w, n, c;
      cfg_col_end = at_end;
      c = col_cnt;
      push(9'h1FF);
      find_start(20, w);
      wait_n(58);
      jam = 1'b1;
      wait_n(6);
      jam = 1'b0;
      wait_idle(300, n);
      chk(at_end ? "R10 end point sees late jam" : "R10 mid point misses late jam",
          col_cnt - c, exp_cnt);
      chk("R12 tx_en kept without auto clear", tx_en, 1);
      pulse_rd();
      cfg_col_end = 1'b0;
   endtask

   task automatic t_autoclr();
      int w, n, c;
      cfg_auto_clr = 1'b1;
      c = col_cnt;
      push(9'h1FF);
      find_start(20, w);
      wait_n(34);
      jam = 1'b1;
      wait_n(14);
      jam = 1'b0;
      chk("R9 one collision pulse", col_cnt - c, 1);
      chk("R12 tx_en auto cleared", tx_en, 0);
      wait_idle(300, n);
      chk("R12 frame completes", n < 300, 1);
      pulse_rd();
      push(9'h077);
      wait_n(100);
      chk("R12 next char held", txd, 1);
      chk("R12 next char queued", tx_buf_empty, 0);
      pulse_te();
      find_start(20, w);
      chk("R12 sends after te_set", w < 20, 1);
      wait_idle(300, n);
      chk("R12 queued data received", rx_data, 9'h077);
      pulse_rd();
      cfg_auto_clr = 1'b0;
   endtask

   task automatic t_overrun();
      int n;
      push(9'h0C3);
      wait_idle(300, n);
      push(9'h13C);
      wait_idle(300, n);
      wait_n(4);
      chk("R6 err_ovr", err_ovr, 1);
      chk("R6 newer data kept", rx_data, 9'h13C);
      chk("R8 err_sum on overrun", err_sum, 1);
      chk("R8 err_par zero", err_par, 0);
      pulse_rd();
      chk("R6 cleared", err_ovr, 0);
      chk("R8 err_sum cleared", err_sum, 0);
   endtask

   task automatic t_framing();
      int w, n;
      push(9'h1FF);
      find_start(20, w);
      wait_n(162);
      jam = 1'b1;
      wait_n(18);
      jam = 1'b0;
      wait_idle(100, n);
      wait_n(4);
      chk("R7 err_frm", err_frm, 1);
      chk("R7 rx_done with error", rx_done, 1);
      chk("R8 err_sum on framing", err_sum, 1);
      pulse_rd();
      chk("R7 cleared", err_frm, 0);
   endtask

   task automatic t_ext();
      int n;
      cfg_ext_src = 1'b1;
      push(9'h0AA);
      wait_n(150);
      chk("R14 stalled in start bit", txd, 0);
      chk("R14 still busy", tx_reg_empty, 0);
      n = 0;
      while (!(tx_reg_empty && tx_buf_empty) && n < 3000) begin
         @(negedge clk);
         n++;
         if (n % 2 == 0) ext_clk = ~ext_clk;
      end
      chk("R14 frame time with ext source", (n >= 690) && (n <= 715), 1);
      chk("R14 data received", rx_data, 9'h0AA);
      pulse_rd();
      ext_clk = 1'b0;
      cfg_ext_src = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      miss++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
   end

   initial begin
      wait_n(4);
      rst_n = 1'b1;
      wait_n(2);
      t_reset();
      t_frame();
      t_inv();
      t_start_wait();
      t_idle_jam();
      t_col_point(1'b0, 0);
      t_col_point(1'b1, 1);
      t_autoclr();
      t_overrun();
      t_framing();
      t_ext();
      summary();
   end
endmodule